// File: doc/BRIEF.md
# Hiccup Overload Restart Sequencer

This block turns repeated current-limit events of a switching regulator into a timed shutdown and restart. A saturating digital accumulator takes the place of the analog restart-timer capacitor. In each switching period that contains a current-limit hit, the accumulator climbs quickly. In a clean period it drains slowly. When the accumulated fault time crosses a trip level, the sequencer stops switching and asks for the soft-start node to be discharged.

The off-time is not a plain timer. The accumulator ramps up and down between an upper and a lower level a fixed number of times, with separate charge and discharge step sizes. After the last down ramp, the sequencer releases soft-start and allows switching again.

A follower phase (slave input high) uses a stronger fault charge step and has no drain steps of its own. An optional latch-off mode keeps the block off after a trip until the enable input goes low. All accumulator updates happen on an internal sub-tick, one enabled clock in every `SUB_DIV`. This keeps the step sizes in a fixed ratio.

Top module: `hiccup_restart_seq`

## Requirements
- R1: During reset, and in every clock after a cycle with `en_i` low, `status_o` = 0 (off), `sw_off_o` = 1, `ss_dis_o` = 1 and `acc_o` = 0. One enabled clock after off, `status_o` becomes 1 (normal) and both control outputs go low.
- R2: `acc_o` changes only on a sub-tick. A sub-tick is every `SUB_DIV`-th clock, counted from the first clock with `en_i` high.
- R3: A fault window opens on the clock where `cur_lim_i` is high. It stays open until a clock where `period_tick_i` is high and `cur_lim_i` is low. On a sub-tick inside the window (or with `cur_lim_i` high), a master adds `FAULT_STEP` (30).
- R4: On a sub-tick outside the fault window, a master subtracts `NORM_DN` (5). The value stops at 0 and never wraps.
- R5: When a running-state update leaves the accumulator above `RESTART_TH` (120), the next state is hiccup (`status_o` = 3) with `sw_off_o` and `ss_dis_o` high.
- R6: In hiccup, the accumulator adds `HIC_UP` (10) per sub-tick until it is at or above `UPPER_TH` (420). It then subtracts `HIC_DN` (5) per sub-tick until it is at or below `LOWER_TH` (215). The ramp up then starts again.
- R7: The down ramp that reaches the lower level for the `RAMP_PAIRS`-th (8th) time ends hiccup. The state returns to normal (1) with `acc_o` = 0, and `sw_off_o` and `ss_dis_o` go low.
- R8: With `slave_i` high, the fault step is `SLAVE_FAULT_STEP` (35). The running drain step and both hiccup ramp steps are zero, so a slave phase stays in hiccup with a constant accumulator.
- R9: With `latch_mode_i` high, a trip goes to latched (`status_o` = 4) instead of hiccup. The accumulator is frozen and switching stays off until `en_i` goes low.
- R10: While running, `status_o` is 2 (accumulating) when the accumulator is non-zero and 1 (normal) when it is zero.
- R11: `cur_lim_i` has no effect on the accumulator during hiccup. With current-limit hits every period, the off-time is still exactly the ramp-count time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Sequencer enable; low forces the off state |
| period_tick_i | input | 1 | One-clock pulse at each switching-period boundary |
| cur_lim_i | input | 1 | Cycle-by-cycle current-limit hit |
| slave_i | input | 1 | Follower-phase configuration |
| latch_mode_i | input | 1 | Stay off after a trip instead of restarting |
| sw_off_o | output | 1 | Switching disable |
| ss_dis_o | output | 1 | Soft-start discharge request |
| status_o | output | 3 | 0 off, 1 normal, 2 accumulating, 3 hiccup, 4 latched |
| acc_o | output | ACC_W | Accumulator level |

## Verification
Every clock is compared against an independent arithmetic model of the requirements. A sweep runs all sixteen four-period fault masks at several hit offsets inside the period. The offsets separate the window that a period boundary closes from the window that a hit in the same clock reopens, and they show net growth against net drain.

Continuous faults from a clean start trip at exactly 150 for a master and 140 for a slave, which tells the two charge steps apart. The measured hiccup length is compared with a ramp count computed in the bench, so a wrong threshold, step or pair count changes the result. A single fault period followed by silence exercises the clamp at zero. Latch and slave runs check that the accumulator holds still.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [2:0] {
    ST_OFF    = 3'd0,
    ST_NORM   = 3'd1,
    ST_ACCUM  = 3'd2,
    ST_HICCUP = 3'd3,
    ST_LATCH  = 3'd4
  } ovl_state_e;
endpackage

// File: rtl/ovl_subtick.sv
module ovl_subtick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i)      cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ovl_fault_window.sv
module ovl_fault_window (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic period_tick_i,
  input  logic cur_lim_i,
  output logic fault_o
);
  logic hit_q;

  // a hit holds until the next period boundary
  always_ff @(posedge clk) begin
    if (rst || !run_i)      hit_q <= 1'b0;
    else if (cur_lim_i)     hit_q <= 1'b1;
    else if (period_tick_i) hit_q <= 1'b0;
  end

  assign fault_o = hit_q | cur_lim_i;
endmodule

// File: rtl/ovl_sat_step.sv
module ovl_sat_step #(
  parameter int W = 10
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] amt_i,
  input  logic         up_i,
  output logic [W-1:0] nxt_o
);
  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, cur_i} + {1'b0, amt_i};
    if (up_i)               nxt_o = sum[W] ? {W{1'b1}} : sum[W-1:0];
    else if (cur_i < amt_i) nxt_o = '0;
    else                    nxt_o = cur_i - amt_i;
  end
endmodule

// File: rtl/hiccup_restart_seq.sv
module hiccup_restart_seq
  import ovl_pkg::*;
#(
  parameter int ACC_W            = 10,
  parameter int SUB_DIV          = 4,
  parameter int FAULT_STEP       = 30,
  parameter int SLAVE_FAULT_STEP = 35,
  parameter int NORM_DN          = 5,
  parameter int HIC_UP           = 10,
  parameter int HIC_DN           = 5,
  parameter int RESTART_TH       = 120,
  parameter int UPPER_TH         = 420,
  parameter int LOWER_TH         = 215,
  parameter int RAMP_PAIRS       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             period_tick_i,
  input  logic             cur_lim_i,
  input  logic             slave_i,
  input  logic             latch_mode_i,
  output logic             sw_off_o,
  output logic             ss_dis_o,
  output logic [2:0]       status_o,
  output logic [ACC_W-1:0] acc_o
);
  localparam int PW = $clog2(RAMP_PAIRS + 1);
  localparam logic [PW-1:0]    LAST_PAIR = PW'(RAMP_PAIRS - 1);
  localparam logic [ACC_W-1:0] TRIP_L    = ACC_W'(RESTART_TH);
  localparam logic [ACC_W-1:0] UPPER_L   = ACC_W'(UPPER_TH);
  localparam logic [ACC_W-1:0] LOWER_L   = ACC_W'(LOWER_TH);
  localparam logic [ACC_W-1:0] F_M       = ACC_W'(FAULT_STEP);
  localparam logic [ACC_W-1:0] F_S       = ACC_W'(SLAVE_FAULT_STEP);
  localparam logic [ACC_W-1:0] DN_M      = ACC_W'(NORM_DN);
  localparam logic [ACC_W-1:0] HU_M      = ACC_W'(HIC_UP);
  localparam logic [ACC_W-1:0] HD_M      = ACC_W'(HIC_DN);

  ovl_state_e       st_q, st_n;
  logic [ACC_W-1:0] acc_q, acc_n, acc_step, amt;
  logic             rise_q, rise_n, step_up;
  logic [PW-1:0]    pair_q, pair_n;
  logic             sub_tick, fault_now, running;

  ovl_subtick #(.DIV(SUB_DIV)) u_tick (
    .clk(clk), .rst(rst), .run_i(en_i), .tick_o(sub_tick)
  );

  ovl_fault_window u_win (
    .clk(clk), .rst(rst), .run_i(en_i), .period_tick_i(period_tick_i),
    .cur_lim_i(cur_lim_i), .fault_o(fault_now)
  );

  assign running = (st_q == ST_NORM) || (st_q == ST_ACCUM);

  // step selection: fault integration while running, triangle ramps in hiccup
  always_comb begin
    if (running) begin
      step_up = fault_now;
      if (fault_now) amt = slave_i ? F_S : F_M;
      else           amt = slave_i ? '0 : DN_M;
    end else begin
      step_up = rise_q;
      if (slave_i)     amt = '0;
      else if (rise_q) amt = HU_M;
      else             amt = HD_M;
    end
  end

  ovl_sat_step #(.W(ACC_W)) u_step (
    .cur_i(acc_q), .amt_i(amt), .up_i(step_up), .nxt_o(acc_step)
  );

  always_comb begin
    st_n   = st_q;
    acc_n  = acc_q;
    rise_n = rise_q;
    pair_n = pair_q;
    if (!en_i) begin
      st_n   = ST_OFF;
      acc_n  = '0;
      rise_n = 1'b1;
      pair_n = '0;
    end else begin
      case (st_q)
        ST_OFF: st_n = ST_NORM;
        ST_NORM, ST_ACCUM: begin
          if (sub_tick) begin
            acc_n = acc_step;
            if (acc_step > TRIP_L) begin
              st_n   = latch_mode_i ? ST_LATCH : ST_HICCUP;
              rise_n = 1'b1;
              pair_n = '0;
            end else begin
              st_n = (acc_step == '0) ? ST_NORM : ST_ACCUM;
            end
          end
        end
        ST_HICCUP: begin
          if (sub_tick) begin
            acc_n = acc_step;
            if (rise_q) begin
              if (acc_step >= UPPER_L) rise_n = 1'b0;
            end else if (acc_step <= LOWER_L) begin
              rise_n = 1'b1;
              if (pair_q == LAST_PAIR) begin
                st_n   = ST_NORM;
                acc_n  = '0;
                pair_n = '0;
              end else begin
                pair_n = pair_q + 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_OFF;
      acc_q    <= '0;
      rise_q   <= 1'b1;
      pair_q   <= '0;
      sw_off_o <= 1'b1;
      ss_dis_o <= 1'b1;
    end else begin
      st_q     <= st_n;
      acc_q    <= acc_n;
      rise_q   <= rise_n;
      pair_q   <= pair_n;
      sw_off_o <= (st_n == ST_OFF) || (st_n == ST_HICCUP) || (st_n == ST_LATCH);
      ss_dis_o <= (st_n == ST_OFF) || (st_n == ST_HICCUP) || (st_n == ST_LATCH);
    end
  end

  assign status_o = st_q;
  assign acc_o    = acc_q;

  a_r1_disable_forces_off: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (status_o == ST_OFF && sw_off_o && ss_dis_o && acc_o == '0));

  a_r2_hold_between_subticks: assert property (@(posedge clk) disable iff (rst)
    (en_i && !sub_tick && status_o != ST_OFF) |=> $stable(acc_o));

  a_r5_off_outputs: assert property (@(posedge clk) disable iff (rst)
    (status_o == ST_HICCUP || status_o == ST_LATCH) |-> (sw_off_o && ss_dis_o));

  a_r6_ramp_ceiling: assert property (@(posedge clk) disable iff (rst)
    (status_o == ST_HICCUP) |-> (int'(acc_o) < UPPER_TH + HIC_UP));

  a_r7_release_clears: assert property (@(posedge clk) disable iff (rst)
    ($past(status_o) == ST_HICCUP && status_o == ST_NORM) |-> (acc_o == '0 && !sw_off_o));

  a_r8_slave_hiccup_frozen: assert property (@(posedge clk) disable iff (rst)
    (en_i && slave_i && status_o == ST_HICCUP) |=> (status_o == ST_HICCUP && $stable(acc_o)));

  a_r9_latch_holds: assert property (@(posedge clk) disable iff (rst)
    (en_i && status_o == ST_LATCH) |=> (status_o == ST_LATCH && $stable(acc_o)));
endmodule

// File: tb/hiccup_restart_seq_tb_top.sv
`timescale 1ns/1ps
module hiccup_restart_seq_tb_top;
  localparam int W = 10, DIV = 4, FS = 30, FSS = 35, ND = 5, HU = 10, HD = 5;
  localparam int TRIP = 120, UP = 420, LO = 215, PAIRS = 8, PER = 10;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, ptick = 1'b0, cl = 1'b0;
  logic slave = 1'b0, latch = 1'b0;
  logic sw_off, ss_dis;
  logic [2:0] status;
  logic [W-1:0] acc;

  int checks = 0, fails = 0;
  int pcnt = 0, cl_off = 0;
  bit fault_on = 0;
  bit [3:0] fmask = 4'hF;
  string cur_req = "R1";

  // reference model state
  int md_cnt = 0, md_st = 0, md_acc = 0, md_pr = 0;
  bit md_flag = 0, md_up = 1;

  always #2.5 clk = ~clk;

  hiccup_restart_seq dut_i (
    .clk(clk), .rst(rst), .en_i(en), .period_tick_i(ptick), .cur_lim_i(cl),
    .slave_i(slave), .latch_mode_i(latch), .sw_off_o(sw_off), .ss_dis_o(ss_dis),
    .status_o(status), .acc_o(acc)
  );

  function automatic int addc(int a, int s);
    return (a + s > MAXV) ? MAXV : a + s;
  endfunction
  function automatic int subc(int a, int s);
    return (a < s) ? 0 : a - s;
  endfunction

  // number of sub-ticks spent off for a master entering at level a
  function automatic int hic_ticks(int a0);
    int a = a0, n = 0, p = 0;
    bit u = 1;
    while (p < PAIRS) begin
      n++;
      if (u) begin a += HU; if (a >= UP) u = 0; end
      else begin a -= HD; if (a <= LO) begin u = 1; p++; end end
    end
    return n;
  endfunction

  always @(posedge clk) begin
    bit tk, fl;
    if (rst) begin
      md_cnt = 0; md_flag = 0; md_st = 0; md_acc = 0; md_up = 1; md_pr = 0;
    end else begin
      tk = en && (md_cnt == DIV - 1);
      fl = md_flag || cl;
      md_cnt  = (!en || tk) ? 0 : md_cnt + 1;
      md_flag = !en ? 0 : (cl ? 1 : (ptick ? 0 : md_flag));
      if (!en) begin
        md_st = 0; md_acc = 0; md_up = 1; md_pr = 0;
      end else if (md_st == 0) begin
        md_st = 1;
      end else if ((md_st == 1 || md_st == 2) && tk) begin
        md_acc = fl ? addc(md_acc, slave ? FSS : FS) : subc(md_acc, slave ? 0 : ND);
        if (md_acc > TRIP) begin md_st = latch ? 4 : 3; md_up = 1; md_pr = 0; end
        else md_st = (md_acc == 0) ? 1 : 2;
      end else if (md_st == 3 && tk) begin
        if (md_up) begin
          md_acc = addc(md_acc, slave ? 0 : HU);
          if (md_acc >= UP) md_up = 0;
        end else begin
          md_acc = subc(md_acc, slave ? 0 : HD);
          if (md_acc <= LO) begin
            md_up = 1;
            if (md_pr == PAIRS - 1) begin md_st = 1; md_acc = 0; md_pr = 0; end
            else md_pr++;
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      bit eoff;
      eoff = (md_st == 0 || md_st == 3 || md_st == 4);
      chk(int'(acc) == md_acc, cur_req, "acc", int'(acc), md_acc);
      chk(int'(status) == md_st, cur_req, "status", int'(status), md_st);
      chk(sw_off == eoff && ss_dis == eoff, cur_req, "sw_off/ss_dis",
          int'({sw_off, ss_dis}), eoff ? 3 : 0);
    end
  end

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      pcnt++;
      ptick = (pcnt % PER == 0);
      cl = fault_on && (pcnt % PER == cl_off) && fmask[(pcnt / PER) % 4];
    end
  endtask

  task automatic wait_st(int s);
    int g = 0;
    while (int'(status) != s && g < 20000) begin run(1); g++; end
  endtask

  task automatic restart();
    en = 0; run(2); en = 1; run(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, a1;
    run(3);
    chk(status == 3'd0 && sw_off && ss_dis && acc == '0, "R1", "reset state",
        int'(status), 0);
    rst = 0; run(2);
    chk(status == 3'd0 && sw_off, "R1", "disabled", int'(status), 0);
    en = 1; run(1);
    chk(status == 3'd1 && !sw_off && !ss_dis, "R1", "enable -> normal", int'(status), 1);

    // continuous faults from a clean start
    cur_req = "R3"; cl_off = 0; fmask = 4'hF; fault_on = 1;
    wait_st(3);
    chk(int'(acc) == 150, "R5", "trip level", int'(acc), 150);
    chk(sw_off && ss_dis, "R5", "off on trip", int'({sw_off, ss_dis}), 3);
    cur_req = "R6"; n = 0;
    while (status == 3'd3 && n < 20000) begin run(1); n++; end
    chk(n == hic_ticks(150) * DIV, "R11", "off-time cycles with hits", n, hic_ticks(150) * DIV);
    chk(status == 3'd1 && acc == '0 && !sw_off && !ss_dis, "R7", "release", int'(acc), 0);

    // single fault period then silence: drain and floor at zero
    cur_req = "R4"; fault_on = 0; restart(); run(20);
    fault_on = 1; cl_off = 3; run(PER); fault_on = 0; run(1);
    chk(status == 3'd2, "R10", "accumulating", int'(status), 2);
    run(400);
    chk(acc == '0 && status == 3'd1, "R4", "floor at zero", int'(acc), 0);
    run(40);
    chk(acc == '0, "R4", "no wrap", int'(acc), 0);

    // follower phase
    cur_req = "R8"; slave = 1; cl_off = 0; restart();
    fault_on = 1; run(PER); fault_on = 0; run(200);
    a1 = int'(acc);
    chk(a1 > 0 && a1 % FSS == 0, "R8", "slave fault step", a1, FSS);
    run(200);
    chk(int'(acc) == a1, "R8", "no slave drain", int'(acc), a1);
    restart(); fault_on = 1; wait_st(3);
    chk(int'(acc) == 140, "R8", "slave trip level", int'(acc), 140);
    run(600);
    chk(status == 3'd3 && int'(acc) == 140, "R8", "slave stays off", int'(acc), 140);

    // latch-off
    cur_req = "R9"; slave = 0; latch = 1; restart(); wait_st(4);
    chk(int'(acc) == 150 && sw_off, "R9", "latched on trip", int'(acc), 150);
    fault_on = 0; run(300);
    chk(status == 3'd4 && sw_off && int'(acc) == 150, "R9", "latched holds", int'(status), 4);
    en = 0; run(1);
    chk(status == 3'd0 && acc == '0, "R1", "disable clears latch", int'(status), 0);
    latch = 0;

    // sweep fault masks and hit offsets
    cur_req = "R2";
    for (int m = 0; m < 16; m++) begin
      for (int o = 0; o < PER; o += 3) begin
        fmask = m[3:0]; cl_off = o; fault_on = 1;
        restart(); run(250);
      end
    end
    fault_on = 0; run(5);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule